// File: doc/BRIEF.md
# Two-Wire DAC Channel Register Bank

This block is a target on a two-wire I2C bus that holds twenty 10-bit converter channel codes. Each channel has two stages. A bus write fills the staging register, and the code only reaches the parallel output when a separate latch strobe copies every staging register into its output latch in the same clock. This lets a host load a whole set of codes over the bus, then make all of them take effect together.

A write transfer carries the target address, a channel pointer byte, and then pairs of data bytes. In each pair the high-order byte comes first. The pointer advances after each pair. A read transfer first sets the pointer in a write phase. After a repeated START, or a STOP followed by a START, the target returns the latched channel values two bytes at a time and advances the pointer after each pair until the controller answers a byte with a NACK.

SCL and SDA are oversampled by the system clock. The target drives SDA only as an open-drain pull-down enable. It never stretches the clock.

Top module: `dacreg_i2c_target`

## Requirements
- R1: A transfer whose 7-bit address differs from the DEV_ADDR parameter is ignored: `sda_oe` stays low until the next START, and no state changes.
- R2: When the address byte matches, the target acknowledges it by driving SDA low during the ninth clock. This applies with the R/W bit low (write phase) and with it high (read phase).
- R3: A pointer byte is acknowledged only when its bits 7:5 are zero and its bits 4:0 are below 20. Any other pointer byte gets a NACK, and the data bytes that follow it are neither acknowledged nor stored.
- R4: After an accepted pointer, data bytes form pairs. The first byte supplies value bits 9:8 from its bits 1:0, and its bits 7:2 are ignored. The second byte supplies bits 7:0. The target acknowledges each byte, stores the value in the staging register of the pointed channel, and advances the pointer, wrapping from 19 to 0.
- R5: Staging writes do not change `out_values`. One cycle of `load_strobe` copies all twenty staging registers into the output latches, and the outputs show the new values one clock later. Channel k occupies bits [10k+9:10k].
- R6: In the read phase the target sends, for the pointed channel, a high byte {6'b0, value[9:8]} and then a low byte value[7:0], most significant bit first.
- R7: Readback returns the output latch contents, even when the staging register holds a different value.
- R8: After each two-byte pair the read pointer advances, wrapping from channel 19 to 0. The pointer persists between transfers.
- R9: A NACK from the controller ends the read. The target then leaves SDA released for any further clocks until the next START.
- R10: A STOP or START at any point, including in the middle of a data pair, releases SDA, returns the target to waiting for an address, and discards a half-received pair.
- R11: `sda_oe` changes only while SCL is low.
- R12: While reset is asserted, all outputs are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| load_strobe | input | 1 | Copies every staging register into its output latch |
| out_values | output | NCH*VW (200) | Latched channel codes, channel 0 in the low bits |

## Verification
The bench instantiates the block with its default parameters: twenty channels, 10-bit codes, address 0x4A and a two-stage synchronizer. With these values both wrap points can be reached: a write that runs past channel 19 lands in channel 0, and a read started at channel 19 returns channel 19 and then channel 0. The two meaningful bits of the high byte can be checked against ignored upper bits in the written data. Pointer values 20 and 0x23 exercise both ways a pointer byte can be rejected.

// File: rtl/dacreg_pkg.sv
// Shared definitions for the two-wire channel register bank.
// Assumes the pointer field in the pointer byte is five bits wide.
package dacreg_pkg;

    // Width of the channel-select field inside the pointer byte
    localparam int PTR_W = 5;

    // Byte engine states
    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_PTR,
        S_PTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_TX,
        S_TX_ACK
    } fsm_state_t;

endpackage

// File: rtl/dacreg_bus_sync.sv
// Bus line front end: brings SCL and SDA into the clk domain through a
// synchronizer chain and flags clock edges and START/STOP conditions.
// Assumes clk is several times faster than SCL.
module dacreg_bus_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_N-1:0] scl_ff;
    logic [SYNC_N-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Synchronizer chains plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
            scl_d  <= scl_ff[SYNC_N-1];
            sda_d  <= sda_ff[SYNC_N-1];
        end
    end

    assign scl_s     = scl_ff[SYNC_N-1];
    assign sda_s     = sda_ff[SYNC_N-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/dacreg_bank.sv
// Channel storage: one staging and one output register per channel.
// A write updates a single staging register. The load strobe copies all
// staging registers into the output registers in one clock.
// Assumes wr_idx and rd_idx are below NCH.
module dacreg_bank #(
    parameter int NCH = 20,
    parameter int VW  = 10,
    parameter int PW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  logic [VW-1:0]     wr_data,
    input  logic              load,
    input  logic [PW-1:0]     rd_idx,
    output logic [VW-1:0]     rd_val,
    output logic [NCH*VW-1:0] live_flat
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [VW-1:0] stage_r;
        logic [VW-1:0] live_r;

        // Staging register loads on a matching write; output register on strobe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_r <= '0;
                live_r  <= '0;
            end else begin
                if (wr_en && wr_idx == PW'(g)) stage_r <= wr_data;
                if (load) live_r <= stage_r;
            end
        end

        assign live_flat[g*VW +: VW] = live_r;
    end

    // Readback multiplexer over the output registers
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_idx == PW'(i)) rd_val = live_flat[i*VW +: VW];
        end
    end

endmodule

// File: rtl/dacreg_i2c_fsm.sv
// Byte engine of the bus target: receives the address, pointer and data
// bytes, sends readback bytes, and drives the acknowledge bits.
// Assumes synchronized inputs and 9 <= VW <= 16. SDA changes only after a
// detected SCL fall.
module dacreg_i2c_fsm
    import dacreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4A,
    parameter int         NCH      = 20,
    parameter int         VW       = 10,
    parameter int         PW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [VW-1:0] rd_val,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic [VW-1:0] wr_data,
    output logic [PW-1:0] rd_idx
);

    localparam int          HW   = VW - 8;
    localparam logic [PW-1:0] LAST = PW'(NCH - 1);

    fsm_state_t     st;
    logic [7:0]     sr;
    logic [3:0]     cnt;
    logic           rw;
    logic [PW-1:0]  ptr;
    logic [HW-1:0]  hi_q;
    logic           lo_sel;
    logic           mack;

    logic [15:0]    rd_word;
    logic [7:0]     hi_byte;
    logic [7:0]     lo_byte;
    logic [PW-1:0]  ptr_next;
    logic           ptr_ok;
    logic           rx_state;
    logic           rx_done;

    // Derived values for the byte engine
    always_comb begin
        rd_word  = 16'(rd_val);
        hi_byte  = rd_word[15:8];
        lo_byte  = rd_word[7:0];
        ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
        ptr_ok   = (sr[7:PW] == '0) && ({1'b0, sr[PW-1:0]} < (PW+1)'(NCH));
        rx_state = (st == S_ADDR) || (st == S_PTR) || (st == S_WDATA);
        rx_done  = scl_fall && (cnt == 4'd8);
    end

    assign rd_idx = ptr;

    // Transfer sequencing, shifting and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            sr      <= '0;
            cnt     <= '0;
            rw      <= 1'b0;
            ptr     <= '0;
            hi_q    <= '0;
            lo_sel  <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                st     <= S_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
                lo_sel <= 1'b0;
            end else if (stop_det) begin
                st     <= S_IDLE;
                sda_oe <= 1'b0;
            end else begin
                if (rx_state && scl_rise && cnt != 4'd8) begin
                    sr  <= {sr[6:0], sda_s};
                    cnt <= cnt + 4'd1;
                end
                case (st)
                    S_ADDR: if (rx_done) begin
                        cnt <= '0;
                        if (sr[7:1] == DEV_ADDR) begin
                            rw     <= sr[0];
                            sda_oe <= 1'b1;
                            st     <= S_ADDR_ACK;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                    S_PTR: if (rx_done) begin
                        cnt <= '0;
                        if (ptr_ok) begin
                            ptr    <= sr[PW-1:0];
                            lo_sel <= 1'b0;
                            sda_oe <= 1'b1;
                            st     <= S_PTR_ACK;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                    S_WDATA: if (rx_done) begin
                        cnt    <= '0;
                        sda_oe <= 1'b1;
                        st     <= S_WDATA_ACK;
                        if (!lo_sel) begin
                            hi_q   <= sr[HW-1:0];
                            lo_sel <= 1'b1;
                        end else begin
                            wr_en   <= 1'b1;
                            wr_idx  <= ptr;
                            wr_data <= {hi_q, sr};
                            ptr     <= ptr_next;
                            lo_sel  <= 1'b0;
                        end
                    end
                    S_ADDR_ACK: if (scl_fall) begin
                        if (rw) begin
                            sr     <= hi_byte;
                            sda_oe <= ~hi_byte[7];
                            lo_sel <= 1'b1;
                            st     <= S_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= S_PTR;
                        end
                    end
                    S_PTR_ACK, S_WDATA_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= S_WDATA;
                    end
                    S_TX: if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            mack   <= 1'b0;
                            st     <= S_TX_ACK;
                        end else begin
                            cnt    <= cnt + 4'd1;
                            sr     <= {sr[6:0], 1'b0};
                            sda_oe <= ~sr[6];
                        end
                    end
                    S_TX_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                cnt <= '0;
                                st  <= S_TX;
                                if (lo_sel) begin
                                    sr     <= lo_byte;
                                    sda_oe <= ~lo_byte[7];
                                    ptr    <= ptr_next;
                                    lo_sel <= 1'b0;
                                end else begin
                                    sr     <= hi_byte;
                                    sda_oe <= ~hi_byte[7];
                                    lo_sel <= 1'b1;
                                end
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dacreg_i2c_target.sv
// Top of the two-wire channel register bank: bus front end, byte engine
// and channel storage. SDA is open drain: sda_oe high pulls the line low.
// Assumes NCH <= 32 and 9 <= VW <= 16.
module dacreg_i2c_target
    import dacreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4A,
    parameter int         NCH      = 20,
    parameter int         VW       = 10,
    parameter int         SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              load_strobe,
    output logic [NCH*VW-1:0] out_values
);

    localparam int PW = PTR_W;

    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic [VW-1:0] wr_data;
    logic [PW-1:0] rd_idx;
    logic [VW-1:0] rd_val;

    dacreg_bus_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    dacreg_i2c_fsm #(.DEV_ADDR(DEV_ADDR), .NCH(NCH), .VW(VW), .PW(PW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_val    (rd_val),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx)
    );

    dacreg_bank #(.NCH(NCH), .VW(VW), .PW(PW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .load      (load_strobe),
        .rd_idx    (rd_idx),
        .rd_val    (rd_val),
        .live_flat (out_values)
    );

endmodule

// File: rtl/dacreg_checker.sv
// Protocol and storage properties for the two-wire channel register bank,
// attached to the top module by bind.
module dacreg_checker #(
    parameter int NCH = 20,
    parameter int VW  = 10,
    parameter int PW  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              load_strobe,
    input logic [NCH*VW-1:0] out_values,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input logic [PW-1:0]     wr_idx,
    input logic [PW-1:0]     rd_idx
);

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe)) else $error("sda_oe moved while SCL high"); // R11

    AST_LATCH_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_strobe) |-> $stable(out_values)) else $error("outputs moved without strobe"); // R5

    AST_BUS_EVENT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_oe) else $error("SDA held after START/STOP"); // R10

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < (PW+1)'(NCH))) else $error("write to invalid channel"); // R3

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, rd_idx} < (PW+1)'(NCH)) else $error("pointer out of range"); // R8

endmodule

bind dacreg_i2c_target dacreg_checker #(.NCH(NCH), .VW(VW), .PW(dacreg_pkg::PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe      (sda_oe),
    .load_strobe (load_strobe),
    .out_values  (out_values),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .rd_idx      (rd_idx)
);

// File: tb/sim_dacreg_i2c_target.sv
`timescale 1ns/1ps
module sim_dacreg_i2c_target;

    localparam int         NCH = 20;
    localparam int         VW  = 10;
    localparam logic [6:0] DEV = 7'h4A;
    localparam int         Q   = 16;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic load = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NCH*VW-1:0] outv;

    int n_cmp = 0;
    int n_bad = 0;
    int oe_cnt = 0;
    int viol = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;

    logic [VW-1:0] stage_m [NCH];
    logic [VW-1:0] live_m  [NCH];
    int ptr_m = 0;

    exp_t exp_q[$];
    logic [7:0] got_byte;
    event got_ev;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    dacreg_i2c_target #(.DEV_ADDR(DEV), .NCH(NCH), .VW(VW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .load_strobe (load),
        .out_values  (outv)
    );

    // Line observer: pull-down cycles and SDA drive moving under high SCL
    always @(posedge clk) begin
        #1;
        if (sda_oe) oe_cnt++;
        if (rst_n && scl && scl_prev && sda_oe != oe_prev) viol++;
        scl_prev = scl;
        oe_prev  = sda_oe;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor: compares each received byte with the queue head
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                chk("unexpected byte", {24'd0, got_byte}, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, {24'd0, got_byte}, {24'd0, e.val});
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; hc(Q);
        scl = 1'b1;   hc(Q);
        sda_m = 1'b0; hc(Q);
        scl = 1'b0;   hc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hc(Q);
        scl = 1'b1;   hc(Q);
        sda_m = 1'b1; hc(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hc(Q);
            scl = 1'b1;   hc(Q);
            scl = 1'b0;
        end
        sda_m = 1'b1; hc(Q);
        scl = 1'b1;   hc(Q/2);
        acked = ~sda_line;
        hc(Q/2);
        scl = 1'b0;
    endtask

    task automatic get_byte(input logic give_ack);
        logic [7:0] b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hc(Q);
            scl = 1'b1; hc(Q/2);
            b[i] = sda_line;
            hc(Q/2);
            scl = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; hc(Q);
        scl = 1'b1; hc(Q);
        scl = 1'b0; hc(1);
        sda_m = 1'b1;
        got_byte = b;
        -> got_ev;
        hc(1);
    endtask

    task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        put_byte(b, a);
        chk(tag, {31'd0, a}, {31'd0, exp_ack});
    endtask

    // Driver: one data pair into the modelled pointer channel
    task automatic write_pair(input logic [7:0] hb, input logic [7:0] lb);
        send_chk(hb, 1'b1, "R4 high byte ack");
        send_chk(lb, 1'b1, "R4 low byte ack");
        stage_m[ptr_m] = {hb[1:0], lb};
        ptr_m = (ptr_m == NCH - 1) ? 0 : ptr_m + 1;
    endtask

    // Driver: reads n channels, pushing the expected bytes first
    task automatic read_chs(int n, string tag);
        for (int k = 0; k < n; k++) begin
            exp_t eh;
            exp_t el;
            eh.val = {6'd0, live_m[ptr_m][9:8]};
            eh.tag = {tag, " high byte"};
            el.val = live_m[ptr_m][7:0];
            el.tag = {tag, " low byte"};
            exp_q.push_back(eh);
            exp_q.push_back(el);
            ptr_m = (ptr_m == NCH - 1) ? 0 : ptr_m + 1;
            get_byte(1'b1);
            get_byte(k != n - 1);
        end
    endtask

    task automatic pulse_load();
        load = 1'b1; hc(1);
        load = 1'b0; hc(1);
        for (int i = 0; i < NCH; i++) live_m[i] = stage_m[i];
    endtask

    task automatic chk_outputs(string tag);
        for (int i = 0; i < NCH; i++) begin
            chk(tag, {22'd0, outv[i*VW +: VW]}, {22'd0, live_m[i]});
        end
    endtask

    initial begin
        int snap;
        for (int i = 0; i < NCH; i++) begin
            stage_m[i] = '0;
            live_m[i]  = '0;
        end
        hc(5);
        chk("R12 outputs in reset", {31'd0, |outv}, 32'd0);
        chk("R12 SDA released in reset", {31'd0, sda_oe}, 32'd0);
        rst_n = 1'b1;
        hc(5);

        // R4 R5: write two channels, outputs untouched until strobe
        bus_start();
        send_chk({DEV, 1'b0}, 1'b1, "R2 write address ack");
        send_chk(8'h00, 1'b1, "R3 pointer 0 ack");
        ptr_m = 0;
        write_pair(8'hFE, 8'h34);
        write_pair(8'h01, 8'h55);
        bus_stop();
        chk("R5 outputs before strobe", {31'd0, |outv}, 32'd0);
        pulse_load();
        chk_outputs("R5 R4 outputs after strobe");

        // R4: write past channel 19 wraps to 0 (staging only)
        bus_start();
        send_chk({DEV, 1'b0}, 1'b1, "R2 write address ack");
        send_chk(8'h13, 1'b1, "R3 pointer 19 ack");
        ptr_m = 19;
        write_pair(8'h03, 8'hFF);
        write_pair(8'h00, 8'h07);
        bus_stop();

        // R6 R7 R9: read ch0/ch1 via repeated START; latch differs from staging
        bus_start();
        send_chk({DEV, 1'b0}, 1'b1, "R2 write address ack");
        send_chk(8'h00, 1'b1, "R3 pointer 0 ack");
        ptr_m = 0;
        bus_start();
        send_chk({DEV, 1'b1}, 1'b1, "R2 read address ack");
        read_chs(2, "R6 R7 latched readback");
        begin
            exp_t e9;
            e9.val = 8'hFF;
            e9.tag = "R9 released after NACK";
            exp_q.push_back(e9);
        end
        get_byte(1'b0);
        bus_stop();

        // R8: STOP then START read from 19 wraps to channel 0
        pulse_load();
        chk_outputs("R5 R4 wrapped write latched");
        bus_start();
        send_chk({DEV, 1'b0}, 1'b1, "R2 write address ack");
        send_chk(8'h13, 1'b1, "R3 pointer 19 ack");
        ptr_m = 19;
        bus_stop();
        bus_start();
        send_chk({DEV, 1'b1}, 1'b1, "R2 read address ack");
        read_chs(2, "R8 wrap readback");
        bus_stop();

        // R3: rejected pointers, following data ignored, pointer kept
        bus_start();
        send_chk({DEV, 1'b0}, 1'b1, "R2 write address ack");
        send_chk(8'h14, 1'b0, "R3 pointer 20 nack");
        bus_stop();
        bus_start();
        send_chk({DEV, 1'b0}, 1'b1, "R2 write address ack");
        send_chk(8'h23, 1'b0, "R3 pointer 0x23 nack");
        send_chk(8'h02, 1'b0, "R3 data after bad pointer nack");
        send_chk(8'h99, 1'b0, "R3 data after bad pointer nack");
        bus_stop();
        bus_start();
        send_chk({DEV, 1'b1}, 1'b1, "R2 read address ack");
        read_chs(1, "R3 R8 pointer kept");
        bus_stop();
        pulse_load();
        chk_outputs("R3 no store after bad pointer");

        // R1: foreign address never pulls SDA
        snap = oe_cnt;
        bus_start();
        send_chk({7'h4B, 1'b0}, 1'b0, "R1 foreign write address nack");
        send_chk(8'h00, 1'b0, "R1 foreign pointer nack");
        send_chk(8'h01, 1'b0, "R1 foreign data nack");
        bus_stop();
        bus_start();
        send_chk({7'h4B, 1'b1}, 1'b0, "R1 foreign read address nack");
        bus_stop();
        chk("R1 no SDA drive for foreign address", oe_cnt - snap, 32'd0);

        // R10: STOP in the middle of a pair discards the half pair
        bus_start();
        send_chk({DEV, 1'b0}, 1'b1, "R2 write address ack");
        send_chk(8'h05, 1'b1, "R3 pointer 5 ack");
        ptr_m = 5;
        send_chk(8'h02, 1'b1, "R4 high byte ack");
        bus_stop();
        chk("R10 SDA released after STOP", {31'd0, sda_line}, 32'd1);
        bus_start();
        send_chk({DEV, 1'b0}, 1'b1, "R2 write address ack");
        send_chk(8'h05, 1'b1, "R3 pointer 5 ack");
        write_pair(8'h01, 8'h11);
        bus_stop();
        pulse_load();
        chk_outputs("R10 half pair discarded");

        // R10: START in the middle of a pair, then read the same channel
        bus_start();
        send_chk({DEV, 1'b0}, 1'b1, "R2 write address ack");
        send_chk(8'h07, 1'b1, "R3 pointer 7 ack");
        ptr_m = 7;
        send_chk(8'h03, 1'b1, "R4 high byte ack");
        bus_start();
        send_chk({DEV, 1'b1}, 1'b1, "R10 read after early START");
        read_chs(1, "R10 readback after early START");
        bus_stop();
        pulse_load();
        chk_outputs("R10 early START leaves channel");

        hc(20);
        chk("R11 SDA drive changes under high SCL", viol, 32'd0);
        chk("scoreboard drained", exp_q.size(), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule